// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the access address for a synchronous SRAM port that never needs an idle cycle between reads and writes. Every enabled clock is either a load, which takes a fresh starting address from outside, or an advance, which steps a small internal beat counter and derives the next address of the burst from the stored start. The upper address bits always come from the stored start. The low bits follow one of two wrapping orders over four beats.

The address output is combinational within the cycle. A load cycle presents the incoming address at once. An advance cycle presents the next beat. State is captured on the rising clock edge when the enable is high. The order input is sampled every cycle: low gives an additive wrap, and high gives an XOR pattern. There is no data stream here, so every pin is a plain control or address signal with no handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: When `en` is 1 and `adv` is 0 (load), `addr_out` equals `addr_in` in that same cycle, and `addr_in` becomes the stored start with beat count 0.
- R2: When `adv` is 1 (advance), the beat count increments modulo 4. `addr_out` takes its upper bits (all bits above bit 1) from the stored start and never from `addr_in`.
- R3: The sequence wraps after four beats: the fourth advance after a load presents the loaded address again, and further advances repeat the same four values.
- R4: With `order_sel` = 0 (linear), `addr_out[1:0]` equals the stored start's low two bits plus the beat count, modulo 4. From start 2 this gives 2, 3, 0, 1.
- R5: With `order_sel` = 1 (interleaved), `addr_out[1:0]` equals the stored start's low two bits XOR the beat count. From start 1 this gives 1, 0, 3, 2.
- R6: A load or an advance is accepted on every enabled cycle with no gap. A load arriving mid-burst restarts the sequence from the new address.
- R7: Synchronous reset clears the stored start and the beat count. Advances with no load after reset produce 1, 2, 3, 0 in linear order, with the upper bits 0.
- R8: While `en` is 0, no state changes whatever `adv` and `addr_in` are. The sequence resumes where it stopped once `en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; state updates only when 1 |
| adv | input | 1 | 0 = load `addr_in`, 1 = advance the burst |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved (XOR) order |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Effective access address for this cycle |

## Verification
A corrupted beat counter shows on the very next advance: the low two bits of `addr_out` skip or repeat a value against the model's sequence. A stored start that is lost or wrongly captured shows on the first advance after the load, as wrong upper bits or a wrong burst origin. Because the output is combinational over the registered state, each fault appears in the first cycle that reads the bad state, at most one clock after it is written. The tests sweep every start offset in both orders, run past the wrap, and insert loads mid-burst, enable gaps and resets, so each register is read soon after it is disturbed.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_reg.sv
module burst_beat_reg #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_sel,
  output logic [BEAT_W-1:0] beat_nxt
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;

  // Load restarts at beat 0 on the new address; advance steps modulo 2**BEAT_W.
  assign beat_nxt = load ? '0 : beat_q + 1'b1;
  assign base_sel = load ? addr_in : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (en) begin
      base_q <= base_sel;
      beat_q <= beat_nxt;
    end
  end

  // R8: disabled cycles leave all state untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(base_q) && $stable(beat_q)));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] offs
);
  logic [BEAT_W-1:0] lin_offs;
  logic [BEAT_W-1:0] xor_offs;

  assign lin_offs = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_offs[b] = start_lo[b] ^ beat[b];
  end

  assign offs = (order == ORD_XOR) ? xor_offs : lin_offs;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_sel;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] offs;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  burst_beat_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (!adv),
    .addr_in  (addr_in),
    .base_sel (base_sel),
    .beat_nxt (beat_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order    (order),
    .start_lo (base_sel[BEAT_W-1:0]),
    .beat     (beat_nxt),
    .offs     (offs)
  );

  assign addr_out = {base_sel[ADDR_W-1:BEAT_W], offs};

  // R1: a load cycle presents the incoming address unchanged
  p_load_thru_r1: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) |-> (addr_out == addr_in));

  // R2: the first advance after a load keeps the loaded upper bits
  p_upper_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) ##1 (en && adv) |->
      (addr_out[ADDR_W-1:BEAT_W] == $past(addr_in[ADDR_W-1:BEAT_W])));

  // R4: consecutive linear advances step the low bits by one
  p_linear_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en && adv && !order_sel) ##1 (en && adv && !order_sel) |->
      (addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1));

  // R5: the first interleaved beat flips bit 0 of the loaded start
  p_xor_first_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !adv) ##1 (en && adv && order_sel) |->
      (addr_out[BEAT_W-1:0] == ($past(addr_in[BEAT_W-1:0]) ^ BEAT_W'(1))));

  // HI_W is kept for readers sizing the upper field
  initial begin
    if (HI_W < 1) $display("burst_addr_seq: ADDR_W must exceed BEAT_W");
  end
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          adv = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .en(en), .adv(adv),
    .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
  );

  // Table entries: {order, start address, advances after the load}
  localparam int NV = 8;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 16'h1230, 4'd5}, {1'b0, 16'hA5A1, 4'd5},
    {1'b0, 16'h0F02, 4'd5}, {1'b0, 16'hFFFF, 4'd5},
    {1'b1, 16'h4440, 4'd5}, {1'b1, 16'h7001, 4'd5},
    {1'b1, 16'h8882, 4'd5}, {1'b1, 16'h0003, 4'd5}
  };

  function automatic logic [AW-1:0] model(logic [AW-1:0] base, int k, logic ord);
    logic [1:0] kk;
    kk = 2'(k);
    return {base[AW-1:2], ord ? (base[1:0] ^ kk) : (base[1:0] + kk)};
  endfunction

  task automatic chk(logic [AW-1:0] exp, string req);
    n_chk++;
    if (addr_out !== exp) begin
      n_err++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  // Drive at the falling edge, sample 2 ns later, state updates at the next rise.
  task automatic cyc(logic e, logic a, logic o, logic [AW-1:0] ad);
    @(negedge clk);
    en = e; adv = a; order_sel = o; addr_in = ad;
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R7: advances straight after reset run from address zero
    for (int k = 1; k <= 4; k++) begin
      cyc(1, 1, 0, 16'hBEEF);
      chk(model('0, k, 1'b0), "R7");
    end

    // Table walk: R1 load, R2/R4/R5 ordering, R3 wrap past four beats
    for (int v = 0; v < NV; v++) begin
      logic o;
      logic [AW-1:0] st;
      o  = VEC[v][20];
      st = VEC[v][19:4];
      cyc(1, 0, o, st);
      chk(st, "R1");
      for (int k = 1; k <= int'(VEC[v][3:0]); k++) begin
        cyc(1, 1, o, ~st);
        if (k == 4) chk(st, "R3");
        else chk(model(st, k, o), o ? "R5" : "R4");
      end
    end

    // R6: load in the middle of a burst, every cycle active
    cyc(1, 0, 0, 16'h0040); chk(16'h0040, "R6");
    cyc(1, 1, 0, 16'h0000); chk(16'h0041, "R6");
    cyc(1, 0, 1, 16'h1113); chk(16'h1113, "R6");
    cyc(1, 1, 1, 16'h2222); chk(16'h1112, "R6");
    cyc(1, 1, 1, 16'h2222); chk(16'h1111, "R6");

    // R8: disabled cycles with loads and advances change nothing
    cyc(1, 0, 0, 16'h0500); chk(16'h0500, "R8");
    cyc(1, 1, 0, 16'h0000); chk(16'h0501, "R8");
    cyc(0, 1, 0, 16'h0000);
    cyc(0, 0, 0, 16'h7777);
    cyc(0, 1, 0, 16'h0000);
    cyc(1, 1, 0, 16'h0000); chk(16'h0502, "R8");
    cyc(1, 1, 0, 16'h0000); chk(16'h0503, "R8");

    // R7: reset in mid-burst returns to base zero, beat zero
    cyc(1, 0, 0, 16'h9992);
    cyc(1, 1, 0, 16'h0000);
    @(negedge clk); rst = 1'b1; en = 1'b1; adv = 1'b1;
    @(negedge clk); rst = 1'b0;
    #2;
    chk(16'h0001, "R7");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule